// File: doc/BRIEF.md
# Programmable Three-Port Parallel I/O Controller

This block gives a host bus three 8-bit parallel ports, named A, B and C, plus a control register. The host picks a target with an active-low chip select and a two-bit register address, then moves a byte with active-low read or write strobes. A configuration word in the control register sets the direction of four groups: port A, port B, the upper nibble of port C and the lower nibble of port C. The block supports only the simple I/O mode. A second kind of control word sets or clears one port C output bit without touching the other bits.

Every port pin has its own input, output and output-enable signal, so the pads stay outside the block. A group set to output drives its latch onto its pins. A group set to input releases them, and a read then returns the pin levels. Configuration words that ask for a handshake mode are refused and leave the block unchanged.

Top module: `pio3_ctrl`

## Requirements
- R1: While `rst` is high and on the cycle after it falls, every output enable is 0 and every output latch is 0. A read of the control register then returns 8'h9B (all four groups input).
- R2: Select codes with `cs_n` low: `addr` 0 is port A, 1 is port B, 2 is port C and 3 is the control register. With `cs_n` high a write changes nothing and `rdata` is 0. `rdata` is also 0 whenever `rd_n` is high.
- R3: A control write with bit 7 = 1, bits 6:5 = 00 and bit 2 = 0 is a configuration word. Bit 4 sets port A, bit 3 port C upper, bit 1 port B and bit 0 port C lower, with 1 meaning input. A group set to output has all of its enable bits at 1 from the next cycle on.
- R4: An accepted configuration word clears all three output latches to 0.
- R5: A write to a data port loads that port's latch on the clock edge where `cs_n` and `wr_n` are both low. The new value appears on its `*_out` pins after that edge.
- R6: A port read returns the pins of input groups and the latch of output groups. For port C this choice is made per nibble. A control register read returns {1, 00, A dir, C-upper dir, 0, B dir, C-lower dir}.
- R7: A control write with bit 7 = 0 is a bit set/reset word. Bits 3:1 give the port C bit index, bit 0 = 1 sets that bit and bit 0 = 0 clears it, and bits 6:4 are ignored. No other latch bit and no direction changes.
- R8: A configuration word whose bits 6:5 are not 00, or whose bit 2 is 1, is ignored. Directions, latches and the control readback all stay as they were.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| addr | input | 2 | Register select |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data, 0 when not reading |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The bench sets port C to a split configuration and drives its pins so that they differ from its latch. A design that muxed the whole byte instead of each nibble would then return the wrong half. Bit set/reset words carry junk in bits 6:4, so a design that decoded the index from the wrong field would change the wrong bit. Handshake-mode words and writes with chip select high come between known states, so a design that accepted either would change its enables, latches or readback. Each new configuration follows latch writes, so a design that kept stale latch values would show them on the pins.

// File: rtl/pio3_pkg.sv
package pio3_pkg;

    localparam int DW      = 8;
    localparam int NIB     = DW / 2;
    localparam int IDX_W   = $clog2(DW);
    localparam int NPORT   = 3;

    // control word field positions
    localparam int CW_KIND = 7;
    localparam int CW_AMHI = 6;
    localparam int CW_AMLO = 5;
    localparam int CW_ADIR = 4;
    localparam int CW_CUDR = 3;
    localparam int CW_BMOD = 2;
    localparam int CW_BDIR = 1;
    localparam int CW_CLDR = 0;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_PA,
        SEL_PB,
        SEL_PC,
        SEL_CTL
    } sel_e;

    typedef struct packed {
        logic a_in;
        logic cu_in;
        logic b_in;
        logic cl_in;
    } dir_cfg_t;

    typedef struct packed {
        logic [IDX_W-1:0] idx;
        logic             val;
    } bitop_t;

    localparam dir_cfg_t CFG_RESET = '{a_in: 1'b1, cu_in: 1'b1, b_in: 1'b1, cl_in: 1'b1};

    function automatic logic is_cfg_word(input logic [DW-1:0] w);
        return w[CW_KIND];
    endfunction

    function automatic logic is_simple_mode(input logic [DW-1:0] w);
        return (w[CW_AMHI] == 1'b0) && (w[CW_AMLO] == 1'b0) && (w[CW_BMOD] == 1'b0);
    endfunction

    function automatic dir_cfg_t cfg_from_word(input logic [DW-1:0] w);
        dir_cfg_t c;
        c.a_in  = w[CW_ADIR];
        c.cu_in = w[CW_CUDR];
        c.b_in  = w[CW_BDIR];
        c.cl_in = w[CW_CLDR];
        return c;
    endfunction

    function automatic logic [DW-1:0] cfg_to_word(input dir_cfg_t c);
        logic [DW-1:0] w;
        w = '0;
        w[CW_KIND] = 1'b1;
        w[CW_ADIR] = c.a_in;
        w[CW_CUDR] = c.cu_in;
        w[CW_BDIR] = c.b_in;
        w[CW_CLDR] = c.cl_in;
        return w;
    endfunction

    function automatic bitop_t bitop_from_word(input logic [DW-1:0] w);
        bitop_t b;
        b.idx = w[IDX_W:1];
        b.val = w[0];
        return b;
    endfunction

    // per-pin input mask for a port: 1 = pin is an input
    function automatic logic [DW-1:0] dir_mask(input dir_cfg_t c, input int port);
        logic [DW-1:0] m;
        case (port)
            0:       m = {DW{c.a_in}};
            1:       m = {DW{c.b_in}};
            default: m = {{NIB{c.cu_in}}, {NIB{c.cl_in}}};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pio3_regsel.sv
module pio3_regsel
    import pio3_pkg::*;
(
    input  logic       cs_n,
    input  logic [1:0] addr,
    output sel_e       sel
);
    always_comb begin
        if (cs_n) begin
            sel = SEL_NONE;
        end else begin
            case (addr)
                2'd0:    sel = SEL_PA;
                2'd1:    sel = SEL_PB;
                2'd2:    sel = SEL_PC;
                default: sel = SEL_CTL;
            endcase
        end
    end
endmodule

// File: rtl/pio3_cfg.sv
module pio3_cfg
    import pio3_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          ctl_wr,
    input  logic [DW-1:0] wdata,
    output dir_cfg_t      cfg,
    output logic          cfg_load,
    output logic          bit_op,
    output bitop_t        bit_cmd
);
    dir_cfg_t cfg_q;

    always_comb begin
        cfg_load = ctl_wr && is_cfg_word(wdata) && is_simple_mode(wdata);
        bit_op   = ctl_wr && !is_cfg_word(wdata);
        bit_cmd  = bitop_from_word(wdata);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= CFG_RESET;
        end else if (cfg_load) begin
            cfg_q <= cfg_from_word(wdata);
        end
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/pio3_port.sv
module pio3_port
    import pio3_pkg::*;
#(
    parameter int  W       = DW,
    parameter bit  HAS_BIT = 1'b0
)(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic                 wr_en,
    input  logic [W-1:0]         wdata,
    input  logic                 bit_en,
    input  logic [$clog2(W)-1:0] bit_idx,
    input  logic                 bit_val,
    input  logic [W-1:0]         in_mask,
    input  logic [W-1:0]         pin_in,
    output logic [W-1:0]         latch,
    output logic [W-1:0]         oe,
    output logic [W-1:0]         rd_val
);
    logic [W-1:0] lat_q;
    logic [W-1:0] lat_d;

    always_comb begin
        lat_d = lat_q;
        if (clr) begin
            lat_d = '0;
        end else if (wr_en) begin
            lat_d = wdata;
        end else if (HAS_BIT && bit_en) begin
            lat_d[bit_idx] = bit_val;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lat_q <= '0;
        end else begin
            lat_q <= lat_d;
        end
    end

    assign latch  = lat_q;
    assign oe     = ~in_mask;
    assign rd_val = (pin_in & in_mask) | (lat_q & ~in_mask);
endmodule

// File: rtl/pio3_ctrl.sv
module pio3_ctrl
    import pio3_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cs_n,
    input  logic [1:0] addr,
    input  logic       rd_n,
    input  logic       wr_n,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic [7:0] pa_in,
    output logic [7:0] pa_out,
    output logic [7:0] pa_oe,
    input  logic [7:0] pb_in,
    output logic [7:0] pb_out,
    output logic [7:0] pb_oe,
    input  logic [7:0] pc_in,
    output logic [7:0] pc_out,
    output logic [7:0] pc_oe
);
    sel_e     sel;
    dir_cfg_t cfg;
    logic     cfg_load;
    logic     bit_op;
    bitop_t   bit_cmd;

    logic [DW-1:0] pin_arr [NPORT];
    logic [DW-1:0] lat_arr [NPORT];
    logic [DW-1:0] oe_arr  [NPORT];
    logic [DW-1:0] rd_arr  [NPORT];
    logic          pwr     [NPORT];

    pio3_regsel u_sel (
        .cs_n (cs_n),
        .addr (addr),
        .sel  (sel)
    );

    pio3_cfg u_cfg (
        .clk      (clk),
        .rst      (rst),
        .ctl_wr   (!wr_n && (sel == SEL_CTL)),
        .wdata    (wdata),
        .cfg      (cfg),
        .cfg_load (cfg_load),
        .bit_op   (bit_op),
        .bit_cmd  (bit_cmd)
    );

    assign pin_arr[0] = pa_in;
    assign pin_arr[1] = pb_in;
    assign pin_arr[2] = pc_in;
    assign pwr[0] = !wr_n && (sel == SEL_PA);
    assign pwr[1] = !wr_n && (sel == SEL_PB);
    assign pwr[2] = !wr_n && (sel == SEL_PC);

    for (genvar gi = 0; gi < NPORT; gi++) begin : g_port
        pio3_port #(
            .W       (DW),
            .HAS_BIT (gi == NPORT - 1)
        ) u_port (
            .clk     (clk),
            .rst     (rst),
            .clr     (cfg_load),
            .wr_en   (pwr[gi]),
            .wdata   (wdata),
            .bit_en  (bit_op),
            .bit_idx (bit_cmd.idx),
            .bit_val (bit_cmd.val),
            .in_mask (dir_mask(cfg, gi)),
            .pin_in  (pin_arr[gi]),
            .latch   (lat_arr[gi]),
            .oe      (oe_arr[gi]),
            .rd_val  (rd_arr[gi])
        );
    end

    assign pa_out = lat_arr[0];
    assign pb_out = lat_arr[1];
    assign pc_out = lat_arr[2];
    assign pa_oe  = oe_arr[0];
    assign pb_oe  = oe_arr[1];
    assign pc_oe  = oe_arr[2];

    always_comb begin
        rdata = '0;
        if (!rd_n) begin
            case (sel)
                SEL_PA:  rdata = rd_arr[0];
                SEL_PB:  rdata = rd_arr[1];
                SEL_PC:  rdata = rd_arr[2];
                SEL_CTL: rdata = cfg_to_word(cfg);
                default: rdata = '0;
            endcase
        end
    end
endmodule

// File: rtl/pio3_ctrl_chk.sv
module pio3_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       cs_n,
    input logic [1:0] addr,
    input logic       rd_n,
    input logic       wr_n,
    input logic [7:0] wdata,
    input logic [7:0] rdata,
    input logic [7:0] pa_out,
    input logic [7:0] pa_oe,
    input logic [7:0] pb_out,
    input logic [7:0] pb_oe,
    input logic [7:0] pc_out,
    input logic [7:0] pc_oe
);
    logic ctl_wr;
    logic rst_seen;
    assign ctl_wr = !cs_n && !wr_n && (addr == 2'd3);

    always_ff @(posedge clk) rst_seen <= rst;

    always @(negedge clk) begin
        if (rst_seen) begin
            AST_RESET_STATE: assert (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00
                                     && pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00); // R1
        end
    end

    AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (rst)
        (cs_n || rd_n) |-> (rdata == 8'h00)); // R2

    AST_OE_ONLY_BY_CTL: assert property (@(posedge clk) disable iff (rst)
        !ctl_wr |=> ($stable(pa_oe) && $stable(pb_oe) && $stable(pc_oe))); // R3

    AST_OE_GROUPED: assert property (@(posedge clk) disable iff (rst)
        ((pa_oe == 8'h00) || (pa_oe == 8'hFF)) && ((pb_oe == 8'h00) || (pb_oe == 8'hFF))
        && ((pc_oe[7:4] == 4'h0) || (pc_oe[7:4] == 4'hF))
        && ((pc_oe[3:0] == 4'h0) || (pc_oe[3:0] == 4'hF))); // R3

    AST_CFG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wdata[7] && wdata[6:5] == 2'b00 && !wdata[2])
        |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00)); // R4

    AST_BITOP_ONE_BIT: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && !wdata[7])
        |=> (((pc_out ^ $past(pc_out)) & ~(8'h01 << $past(wdata[3:1]))) == 8'h00)
            && (pc_out[$past(wdata[3:1])] == $past(wdata[0]))
            && $stable(pa_out) && $stable(pb_out) && $stable(pc_oe)); // R7

    AST_BAD_MODE_IGNORED: assert property (@(posedge clk) disable iff (rst)
        (ctl_wr && wdata[7] && (wdata[6:5] != 2'b00 || wdata[2]))
        |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out))); // R8
endmodule

bind pio3_ctrl pio3_ctrl_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .cs_n   (cs_n),
    .addr   (addr),
    .rd_n   (rd_n),
    .wr_n   (wr_n),
    .wdata  (wdata),
    .rdata  (rdata),
    .pa_out (pa_out),
    .pa_oe  (pa_oe),
    .pb_out (pb_out),
    .pb_oe  (pb_oe),
    .pc_out (pc_out),
    .pc_oe  (pc_oe)
);

// File: tb/pio3_ctrl_test.sv
module pio3_ctrl_test;
    localparam time CLK_PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst;
    logic       cs_n, rd_n, wr_n;
    logic [1:0] addr;
    logic [7:0] wdata, rdata;
    logic [7:0] pa_in, pb_in, pc_in;
    logic [7:0] pa_out, pb_out, pc_out, pa_oe, pb_oe, pc_oe;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    typedef struct {
        logic [7:0] exp;
        string      tag;
    } item_t;

    item_t exp_q[$];
    bit    mon_go = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pio3_ctrl uut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .addr(addr), .rd_n(rd_n), .wr_n(wr_n),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input logic [7:0] got, input logic [7:0] exp, input string tag);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // monitor: pops expected read data and compares away from the clock edge
    always @(negedge clk) begin
        if (mon_go && exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            chk(rdata, it.exp, it.tag);
        end
    end

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d, input logic sel_n);
        @(posedge clk); #1;
        cs_n = sel_n; addr = a; wdata = d; wr_n = 1'b0;
        @(posedge clk); #1;
        cs_n = 1'b1; wr_n = 1'b1;
    endtask

    task automatic bus_read(input logic [1:0] a, input logic sel_n, input logic strobe_n,
                            input logic [7:0] exp, input string tag);
        @(posedge clk); #1;
        cs_n = sel_n; addr = a; rd_n = strobe_n;
        exp_q.push_back('{exp: exp, tag: tag});
        mon_go = 1'b1;
        @(posedge clk); #1;
        mon_go = 1'b0;
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; cs_n = 1'b1; rd_n = 1'b1; wr_n = 1'b1; addr = 2'd0; wdata = 8'h00;
        pa_in = 8'hA5; pb_in = 8'h3C; pc_in = 8'hE7;
        repeat (3) @(posedge clk);
        #1;
        chk(pa_oe | pb_oe | pc_oe, 8'h00, "R1 enables in reset");
        rst = 1'b0;
        @(posedge clk); #1;
        chk(pa_out | pb_out | pc_out, 8'h00, "R1 latches after reset");
        chk(pa_oe | pb_oe | pc_oe, 8'h00, "R1 enables after reset");
        bus_read(2'd3, 1'b0, 1'b0, 8'h9B, "R1 control readback");

        // all inputs: reads follow pins
        bus_read(2'd0, 1'b0, 1'b0, 8'hA5, "R6 port A pins");
        bus_read(2'd1, 1'b0, 1'b0, 8'h3C, "R6 port B pins");
        bus_read(2'd2, 1'b0, 1'b0, 8'hE7, "R6 port C pins");

        // all outputs
        bus_write(2'd3, 8'h80, 1'b0);
        chk(pa_oe & pb_oe & pc_oe, 8'hFF, "R3 all outputs");
        bus_write(2'd0, 8'h3C, 1'b0);
        bus_write(2'd1, 8'hC3, 1'b0);
        bus_write(2'd2, 8'h5A, 1'b0);
        chk(pa_out, 8'h3C, "R5 port A latch");
        chk(pb_out, 8'hC3, "R5 port B latch");
        chk(pc_out, 8'h5A, "R5 port C latch");
        bus_read(2'd0, 1'b0, 1'b0, 8'h3C, "R6 port A latch read");
        bus_read(2'd3, 1'b0, 1'b0, 8'h80, "R6 control readback");

        // split port C: upper input, lower output; A and B output
        bus_write(2'd3, 8'h88, 1'b0);
        chk(pa_out | pb_out | pc_out, 8'h00, "R4 latches cleared");
        chk(pc_oe, 8'h0F, "R3 port C split enables");
        chk(pa_oe & pb_oe, 8'hFF, "R3 A and B output");
        bus_write(2'd2, 8'h5A, 1'b0);
        bus_read(2'd2, 1'b0, 1'b0, 8'hEA, "R6 port C mixed read");

        // bit set/reset with junk in bits 6:4
        bus_write(2'd0, 8'h66, 1'b0);
        bus_write(2'd3, 8'h05, 1'b0);
        chk(pc_out, 8'h5E, "R7 set bit 2");
        bus_write(2'd3, 8'h72, 1'b0);
        chk(pc_out, 8'h5C, "R7 clear bit 1 junk high bits");
        bus_write(2'd3, 8'h4F, 1'b0);
        chk(pc_out, 8'hDC, "R7 set bit 7");
        chk(pa_out, 8'h66, "R7 port A untouched");
        chk(pc_oe, 8'h0F, "R7 directions untouched");
        bus_read(2'd3, 1'b0, 1'b0, 8'h88, "R7 control unchanged");

        // handshake modes refused
        bus_write(2'd3, 8'hA0, 1'b0);
        chk(pc_out, 8'hDC, "R8 mode1 word latch kept");
        chk(pc_oe, 8'h0F, "R8 mode1 word enables kept");
        bus_write(2'd3, 8'hC0, 1'b0);
        bus_write(2'd3, 8'h84, 1'b0);
        chk(pa_out, 8'h66, "R8 mode words latch kept");
        bus_read(2'd3, 1'b0, 1'b0, 8'h88, "R8 control readback kept");

        // chip select high and strobe high
        bus_write(2'd1, 8'hFF, 1'b1);
        chk(pb_out, 8'h00, "R2 write without select ignored");
        bus_read(2'd0, 1'b1, 1'b0, 8'h00, "R2 read without select");
        bus_read(2'd0, 1'b0, 1'b1, 8'h00, "R2 no read strobe");

        // A and B input, C output
        bus_write(2'd3, 8'h92, 1'b0);
        chk(pa_oe | pb_oe, 8'h00, "R3 A and B input");
        chk(pc_oe, 8'hFF, "R3 port C output");
        pa_in = 8'h19; pb_in = 8'h2E;
        bus_read(2'd0, 1'b0, 1'b0, 8'h19, "R6 port A pins again");
        bus_read(2'd1, 1'b0, 1'b0, 8'h2E, "R6 port B pins again");
        bus_read(2'd3, 1'b0, 1'b0, 8'h92, "R6 control readback split");

        repeat (2) @(posedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule